// File: doc/BRIEF.md
# Word-to-Byte Handshaked Disk Port

This block connects a 16-bit CPU register port to an 8-bit bidirectional link that goes to an intelligent disk controller. The controller leads every exchange. The host only starts a selection. After that, the controller asks for each byte with an active-low Request line, and the host answers on an active-low Acknowledge line. Each byte uses a full four-phase handshake.

Selection is a pulse that ends by itself. A CPU write to the status register pulls Select low and drives the data lines with bit 0 low. Select rises again as soon as the controller answers with Busy. A CPU write to the data register queues one word. That word goes out as two byte phases, most significant byte first. In the other direction, the block gathers two incoming bytes into one word and raises a Ready flag, which the CPU sees in the status register. The controller's I/O line chooses the direction. The status register also shows the live levels of Message, C/D, Busy, Request and I/O.

All controller-side inputs are treated as already synchronous to `clk`.

Top module: `wb_disk_port`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `sel_n` and `ack_n` are high, `port_doe` is low and status bit 5 reads 1. `ctl_reset_pull` is 1 in the cycle after any cycle with `rst` high, and 0 after a cycle with `rst` low.
- R2: A cycle with `cpu_wr`=1 and `cpu_addr`=1 makes `sel_n` low from the next cycle. While `sel_n` is low, `port_doe`=1 and `port_dout`=8'hFE (bit 0 low, the other bits high).
- R3: If `busy_n` is sampled low while `sel_n` is low and no status write happens in that cycle, `sel_n` is high in the next cycle.
- R4: A cycle with `cpu_wr`=1 and `cpu_addr`=0 queues `cpu_wdata`. While a word is queued, `io_n`=1 and `busy_n`=0, `port_doe`=1 and `port_dout` shows bits 15:8 first. `ack_n` falls one cycle after `req_n` is sampled low.
- R5: `ack_n` rises one cycle after `req_n` is sampled high while `ack_n` is low. After the first release, `port_dout` shows bits 7:0. After the second release, the word is no longer queued and `port_doe` falls.
- R6: With `io_n`=0, `port_din` is captured each time `req_n` is sampled low while `ack_n` is high and `busy_n` is low, and `ack_n` falls in the next cycle. The first captured byte becomes bits 15:8. One cycle after the second byte's release, status bit 5 reads 0 and the data register (`cpu_addr`=0) reads the assembled word.
- R7: A cycle with `cpu_rd`=1 and `cpu_addr`=0 makes status bit 5 read 1 again from the next cycle.
- R8: The status register (`cpu_addr`=1) reads as follows: bit 5 is the inverted Ready flag, bit 4 is `msg_n`, bit 3 is `cd_n`, bit 2 is `busy_n`, bit 1 is `req_n` and bit 0 is `io_n`. Bits 15:6 read 0.
- R9: `port_doe` is 0 whenever `io_n`=0 and `sel_n` is high.
- R10: A request with `io_n`=1 and no queued word is ignored: `ack_n` stays high and `port_doe` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_rd | input | 1 | CPU register read strobe |
| cpu_addr | input | 1 | Register select: 0 data, 1 status |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data (combinational) |
| port_din | input | 8 | Byte lines as sampled from the link |
| port_dout | output | 8 | Byte driven onto the link |
| port_doe | output | 1 | Output enable for the byte lines |
| sel_n | output | 1 | Select, active low |
| ack_n | output | 1 | Acknowledge, active low |
| ctl_reset_pull | output | 1 | Pull-down request for the open-collector controller reset |
| busy_n | input | 1 | Busy from controller, active low |
| req_n | input | 1 | Request from controller, active low |
| msg_n | input | 1 | Message from controller, active low |
| io_n | input | 1 | Direction: low means controller to host |
| cd_n | input | 1 | Low means a control byte, high means data |

## Verification
`sel_n` and `ack_n` respond exactly one clock after the input they react to is sampled. `port_doe`, `port_dout` and `cpu_rdata` follow the registered state and the current inputs in the same cycle. The Ready flag appears one clock after the second byte's release, and it clears one clock after the data-register read. The bench changes its inputs 2 ns after each rising edge and moves its behavioural model on the rising edge. It then compares every output against that model at the falling edge, so each result is checked in the cycle it is due. Directed checks made 3 ns after an edge cover the reset state, the selection pulse, byte order in both directions, and ignored requests.

// File: rtl/dpp_pkg.sv
package dpp_pkg;

    typedef enum logic {
        DIR_TO_HOST = 1'b0,
        DIR_TO_CTL  = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic msg_n;
        logic cd_n;
        logic busy_n;
        logic req_n;
        logic io_n;
    } ctl_lines_t;

    localparam int STAT_READY_BIT = 5;

    // Byte placed on the link while selecting: bit 0 low, all others high.
    function automatic logic [7:0] select_pattern();
        return 8'hFE;
    endfunction

    // Packs line levels and the inverted ready flag into the low status bits.
    function automatic logic [5:0] status_bits(input ctl_lines_t l, input logic ready);
        return {~ready, l.msg_n, l.cd_n, l.busy_n, l.req_n, l.io_n};
    endfunction

endpackage

// File: rtl/dp_select_pulse.sv
module dp_select_pulse (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic busy_n,
    output logic sel_active
);
    logic sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
        end else if (start) begin
            sel_q <= 1'b1;
        end else if (!busy_n) begin
            sel_q <= 1'b0;
        end
    end

    assign sel_active = sel_q;
endmodule

// File: rtl/dp_byte_engine.sv
module dp_byte_engine
    import dpp_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_word,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rd_word,
    input  logic              busy_n,
    input  logic              req_n,
    input  logic              io_n,
    input  logic [BYTE_W-1:0] din,
    output logic              ack,
    output logic              drive_data,
    output logic [BYTE_W-1:0] byte_out,
    output logic              ready,
    output logic [WORD_W-1:0] rword
);
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int BASE_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

    logic [WORD_W-1:0] wbuf_q;
    logic              wpend_q;
    logic [IDX_W-1:0]  idx_q;
    logic              ack_q;
    xfer_dir_e         dir_q;
    logic [WORD_W-1:0] rbuf_q;
    logic [WORD_W-1:0] rword_q;
    logic              ready_q;
    logic [BASE_W-1:0] lane_base;

    // Most significant lane goes first, so the lane runs opposite to the index.
    always_comb begin
        lane_base = BASE_W'((LANES - 1 - int'(idx_q)) * BYTE_W);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbuf_q  <= '0;
            wpend_q <= 1'b0;
            idx_q   <= '0;
            ack_q   <= 1'b0;
            dir_q   <= DIR_TO_HOST;
            rbuf_q  <= '0;
            rword_q <= '0;
            ready_q <= 1'b0;
        end else begin
            if (rd_word) begin
                ready_q <= 1'b0;
            end
            if (wr_word) begin
                wbuf_q  <= wdata;
                wpend_q <= 1'b1;
                idx_q   <= '0;
            end
            if (!ack_q) begin
                if (!req_n && !busy_n) begin
                    if (io_n) begin
                        if (wpend_q) begin
                            ack_q <= 1'b1;
                            dir_q <= DIR_TO_CTL;
                        end
                    end else begin
                        rbuf_q[lane_base +: BYTE_W] <= din;
                        ack_q <= 1'b1;
                        dir_q <= DIR_TO_HOST;
                    end
                end
            end else if (req_n) begin
                ack_q <= 1'b0;
                if (idx_q == LAST_IDX) begin
                    idx_q <= '0;
                    if (dir_q == DIR_TO_CTL) begin
                        wpend_q <= 1'b0;
                    end else begin
                        rword_q <= rbuf_q;
                        ready_q <= 1'b1;
                    end
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign ack        = ack_q;
    assign drive_data = wpend_q && io_n && !busy_n;
    assign byte_out   = wbuf_q[lane_base +: BYTE_W];
    assign ready      = ready_q;
    assign rword      = rword_q;
endmodule

// File: rtl/dp_status_view.sv
module dp_status_view
    import dpp_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  ctl_lines_t        lines,
    input  logic              ready,
    output logic [WORD_W-1:0] status
);
    always_comb begin
        status      = '0;
        status[5:0] = status_bits(lines, ready);
    end
endmodule

// File: rtl/wb_disk_port.sv
module wb_disk_port
    import dpp_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic              cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    input  logic [BYTE_W-1:0] port_din,
    output logic [BYTE_W-1:0] port_dout,
    output logic              port_doe,
    output logic              sel_n,
    output logic              ack_n,
    output logic              ctl_reset_pull,
    input  logic              busy_n,
    input  logic              req_n,
    input  logic              msg_n,
    input  logic              io_n,
    input  logic              cd_n
);
    localparam logic [BYTE_W-1:0] SEL_BYTE = BYTE_W'(select_pattern());

    logic              sel_active;
    logic              eng_ack;
    logic              eng_drive;
    logic [BYTE_W-1:0] eng_byte;
    logic              eng_ready;
    logic [WORD_W-1:0] eng_word;
    logic [WORD_W-1:0] stat_word;
    logic              rst_q;
    ctl_lines_t        lines;

    assign lines = '{msg_n: msg_n, cd_n: cd_n, busy_n: busy_n, req_n: req_n, io_n: io_n};

    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    dp_select_pulse u_sel (
        .clk       (clk),
        .rst       (rst),
        .start     (cpu_wr && cpu_addr),
        .busy_n    (busy_n),
        .sel_active(sel_active)
    );

    dp_byte_engine #(
        .WORD_W(WORD_W),
        .BYTE_W(BYTE_W)
    ) u_eng (
        .clk       (clk),
        .rst       (rst),
        .wr_word   (cpu_wr && !cpu_addr),
        .wdata     (cpu_wdata),
        .rd_word   (cpu_rd && !cpu_addr),
        .busy_n    (busy_n),
        .req_n     (req_n),
        .io_n      (io_n),
        .din       (port_din),
        .ack       (eng_ack),
        .drive_data(eng_drive),
        .byte_out  (eng_byte),
        .ready     (eng_ready),
        .rword     (eng_word)
    );

    dp_status_view #(
        .WORD_W(WORD_W)
    ) u_stat (
        .lines (lines),
        .ready (eng_ready),
        .status(stat_word)
    );

    assign sel_n          = ~sel_active;
    assign ack_n          = ~eng_ack;
    assign port_doe       = sel_active | eng_drive;
    assign port_dout      = sel_active ? SEL_BYTE : eng_byte;
    assign cpu_rdata      = cpu_addr ? stat_word : eng_word;
    assign ctl_reset_pull = rst_q;
endmodule

// File: rtl/dp_port_checker.sv
module dp_port_checker #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_wr,
    input logic              cpu_addr,
    input logic [WORD_W-1:0] cpu_rdata,
    input logic [BYTE_W-1:0] port_dout,
    input logic              port_doe,
    input logic              sel_n,
    input logic              ack_n,
    input logic              busy_n,
    input logic              req_n,
    input logic              io_n
);
    assert_select_start_R2: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr) |=> (!sel_n && port_doe && !port_dout[0]));

    assert_select_release_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy_n && !sel_n && !(cpu_wr && cpu_addr)) |=> sel_n);

    assert_ack_needs_req_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_n) |-> $past(!req_n));

    assert_ack_release_R5: assert property (@(posedge clk) disable iff (rst)
        (!ack_n && req_n) |=> ack_n);

    assert_no_drive_inbound_R9: assert property (@(posedge clk) disable iff (rst)
        (!io_n && sel_n) |-> !port_doe);

    assert_status_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
        cpu_addr |-> (cpu_rdata[WORD_W-1:6] == '0));
endmodule

bind wb_disk_port dp_port_checker #(
    .WORD_W(WORD_W),
    .BYTE_W(BYTE_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_wr   (cpu_wr),
    .cpu_addr (cpu_addr),
    .cpu_rdata(cpu_rdata),
    .port_dout(port_dout),
    .port_doe (port_doe),
    .sel_n    (sel_n),
    .ack_n    (ack_n),
    .busy_n   (busy_n),
    .req_n    (req_n),
    .io_n     (io_n)
);

// File: tb/wb_disk_port_bench.sv
`timescale 1ns/1ps
module wb_disk_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_addr = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic [7:0]  port_din = '0;
    logic [7:0]  port_dout;
    logic        port_doe, sel_n, ack_n, ctl_reset_pull;
    logic        busy_n = 1'b1, req_n = 1'b1, msg_n = 1'b1, io_n = 1'b1, cd_n = 1'b1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    wb_disk_port u_wb_disk_port (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .port_din(port_din),
        .port_dout(port_dout), .port_doe(port_doe), .sel_n(sel_n), .ack_n(ack_n),
        .ctl_reset_pull(ctl_reset_pull), .busy_n(busy_n), .req_n(req_n),
        .msg_n(msg_n), .io_n(io_n), .cd_n(cd_n)
    );

    // Behavioural reference model
    bit         m_sel, m_ack, m_dir, m_ready, m_rstq;
    logic [7:0] m_wq[$];
    logic [7:0] m_rq[$];
    logic [15:0] m_word;

    always @(posedge clk) begin
        bit set_rdy;
        set_rdy = 1'b0;
        m_rstq = rst;
        if (rst) begin
            m_sel = 0; m_ack = 0; m_dir = 0; m_ready = 0; m_word = '0;
            m_wq.delete(); m_rq.delete();
        end else begin
            if (cpu_wr && cpu_addr) m_sel = 1'b1;
            else if (!busy_n) m_sel = 1'b0;
            if (cpu_wr && !cpu_addr) begin
                m_wq.delete();
                m_wq.push_back(cpu_wdata[15:8]);
                m_wq.push_back(cpu_wdata[7:0]);
            end
            if (!m_ack) begin
                if (!req_n && !busy_n) begin
                    if (io_n) begin
                        if (m_wq.size() > 0) begin m_ack = 1; m_dir = 1; end
                    end else begin
                        m_rq.push_back(port_din); m_ack = 1; m_dir = 0;
                    end
                end
            end else if (req_n) begin
                m_ack = 0;
                if (m_dir) void'(m_wq.pop_front());
                else if (m_rq.size() == 2) begin
                    m_word = {m_rq[0], m_rq[1]};
                    set_rdy = 1'b1;
                    m_rq.delete();
                end
            end
            if (set_rdy) m_ready = 1'b1;
            else if (cpu_rd && !cpu_addr) m_ready = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        logic        e_doe;
        logic [7:0]  e_dout;
        logic [15:0] e_rd;
        if (!done) begin
            e_doe = 0; e_dout = 8'h00;
            if (m_sel) begin e_doe = 1; e_dout = 8'hFE; end
            else if (m_wq.size() > 0 && io_n && !busy_n) begin e_doe = 1; e_dout = m_wq[0]; end
            e_rd = cpu_addr ? {10'b0, ~m_ready, msg_n, cd_n, busy_n, req_n, io_n} : m_word;
            chk("R1 ctl_reset_pull", {15'b0, ctl_reset_pull}, {15'b0, m_rstq});
            chk("R2/R3 sel_n", {15'b0, sel_n}, {15'b0, ~m_sel});
            chk("R4/R5/R6 ack_n", {15'b0, ack_n}, {15'b0, ~m_ack});
            chk("R9/R10 port_doe", {15'b0, port_doe}, {15'b0, e_doe});
            if (e_doe) chk("R2/R4 port_dout", {8'b0, port_dout}, {8'b0, e_dout});
            chk("R6/R8 cpu_rdata", cpu_rdata, e_rd);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic cpu_write(input logic a, input logic [15:0] d);
        cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
        step(1);
        cpu_wr = 0;
    endtask

    task automatic wait_ack(input logic lvl);
        while (ack_n !== lvl) step(1);
    endtask

    task automatic ctl_take(input string tag, input logic [7:0] exp);
        req_n = 0;
        step(1);
        wait_ack(1'b0);
        chk(tag, {8'b0, port_dout}, {8'b0, exp});
        req_n = 1;
        step(1);
        wait_ack(1'b1);
    endtask

    task automatic ctl_give(input logic [7:0] b);
        port_din = b; req_n = 0;
        step(1);
        wait_ack(1'b0);
        req_n = 1;
        step(1);
        wait_ack(1'b1);
    endtask

    task automatic read_word(input string tag, input logic [15:0] exp);
        cpu_addr = 1; #1;
        chk({tag, " ready bit low"}, {15'b0, cpu_rdata[5]}, 16'h0000);
        cpu_addr = 0; #1;
        chk({tag, " word"}, cpu_rdata, exp);
        cpu_rd = 1; step(1); cpu_rd = 0;
        cpu_addr = 1; #1;
        chk("R7 ready cleared after read", {15'b0, cpu_rdata[5]}, 16'h0001);
    endtask

    initial begin
        step(1);
        chk("R1 reset pull during reset", {15'b0, ctl_reset_pull}, 16'h0001);
        step(2);
        rst = 0;
        step(1);
        cpu_addr = 1; #1;
        chk("R1 sel_n idle", {15'b0, sel_n}, 16'h0001);
        chk("R1 ack_n idle", {15'b0, ack_n}, 16'h0001);
        chk("R1 doe idle", {15'b0, port_doe}, 16'h0000);
        chk("R1/R8 status after reset", cpu_rdata, 16'h003F);

        // Selection pulse
        cpu_write(1'b1, 16'h0000); #1;
        chk("R2 sel_n low", {15'b0, sel_n}, 16'h0000);
        chk("R2 select byte", {7'b0, port_doe, port_dout}, 16'h01FE);
        step(3); #1;
        chk("R2 sel held without busy", {15'b0, sel_n}, 16'h0000);
        busy_n = 0;
        step(1); #1;
        chk("R3 sel released on busy", {15'b0, sel_n}, 16'h0001);

        // Host to controller
        io_n = 1; step(1);
        req_n = 0; step(4); #1;
        chk("R10 ignored request ack", {15'b0, ack_n}, 16'h0001);
        chk("R10 ignored request doe", {15'b0, port_doe}, 16'h0000);
        req_n = 1; step(1);
        cpu_write(1'b0, 16'hA55A);
        ctl_take("R4 high byte first", 8'hA5);
        ctl_take("R5 low byte second", 8'h5A);
        #1; chk("R5 doe drops after word", {15'b0, port_doe}, 16'h0000);
        cpu_write(1'b0, 16'h1234);
        ctl_take("R4 high byte word2", 8'h12);
        ctl_take("R5 low byte word2", 8'h34);

        // Controller to host
        io_n = 0; step(1); #1;
        chk("R9 no drive inbound", {15'b0, port_doe}, 16'h0000);
        ctl_give(8'hC3);
        ctl_give(8'h3C);
        read_word("R6 word1", 16'hC33C);
        ctl_give(8'h00);
        ctl_give(8'hFF);
        read_word("R6 word2", 16'h00FF);

        // Status line patterns
        msg_n = 0; cd_n = 1; req_n = 1; io_n = 0; step(1);
        cpu_addr = 1; #1;
        chk("R8 status msg low", cpu_rdata, 16'h002A);
        msg_n = 1; cd_n = 0; busy_n = 1; io_n = 1; step(1); #1;
        chk("R8 status cd low", cpu_rdata, 16'h0037);

        step(3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule